// File: doc/BRIEF.md
# Copy Request Splitting Queue

This block sits in front of a single-transfer copy engine and turns a stream of copy requests into a sequence of engine transfers. Each request carries a source address, a destination address, a byte count and a tag. Requests wait in an in-order queue. The engine only moves up to `2^CHUNK_W - 1` bytes per transfer, so the block cuts longer requests into consecutive pieces. Every piece after the first starts where the previous one ended, in both address spaces.

Before each piece the sequencer goes through the same steps:
1. It waits for the engine to report idle.
2. It pulses a warm reset and waits for idle again.
3. It loads the engine's address and length registers.
4. It pulses start.

Both idle waits are bounded. If a wait expires, a sticky error flag is raised and the sequence continues. When the engine signals that a piece has finished, the block acknowledges the engine's interrupt flag and subtracts the piece length from the request's remaining byte count. It reports the request's tag exactly once, when that count reaches zero.

A combinational query port returns the remaining byte count of any request still held, selected by tag. Tags must be unique among requests still held.

Top module: `copy_split_queue`

## Requirements
- R1: Up to `DEPTH` requests are held, counting the one being executed. `req_ready` is low exactly when `DEPTH` requests are held, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- R2: A request of length L produces ceil(L / MAX) engine transfers, where MAX = `2^CHUNK_W - 1`. Every transfer carries MAX bytes except the last, which carries the remainder.
- R3: A transfer's `eng_src` and `eng_dst` equal the request's addresses plus the sum of the lengths of that request's earlier transfers. The values stay unchanged while the transfer runs.
- R4: Each `eng_start` pulse follows its own `eng_wrst` pulse. That reset is issued only after the engine reads idle (`eng_busy` low) or the wait expires. After the reset, a second idle wait precedes loading the registers, and `eng_start` is a one-cycle pulse issued while the loaded values are present.
- R5: If `eng_busy` stays high for `TIMEOUT` cycles of an idle wait, `timeout_err` is set and stays set until reset, and the sequence still goes on to start the transfer.
- R6: Each `eng_done` is answered with a one-cycle `eng_irq_clr`. `cpl_valid` pulses once per request, with that request's tag on `cpl_tag`, and only after the request's last transfer has completed.
- R7: Transfers and completions follow the order in which requests were accepted. The transfers of one request are never interleaved with those of another.
- R8: `qry_residue` gives the request length for a held request that has not yet completed any transfer. It gives the length minus the bytes of completed transfers for the active request. It gives 0 for a tag that is not held.
- R9: A zero-length request is completed through `cpl_valid` without any `eng_wrst` or `eng_start`.
- R10: After reset, `req_ready` is high and `timeout_err`, `cpl_valid`, `eng_start`, `eng_wrst` and `eng_irq_clr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New request offered |
| req_ready | output | 1 | Queue has room |
| req_src | input | ADDR_W | Request source address |
| req_dst | input | ADDR_W | Request destination address |
| req_len | input | LEN_W | Request byte count |
| req_tag | input | TAG_W | Request tag |
| eng_busy | input | 1 | Engine enable bit (high while active) |
| eng_done | input | 1 | Engine interrupt flag, held until acknowledged |
| eng_wrst | output | 1 | Warm-reset pulse to the engine |
| eng_src | output | ADDR_W | Engine source register |
| eng_dst | output | ADDR_W | Engine destination register |
| eng_len | output | CHUNK_W | Engine length register |
| eng_start | output | 1 | Enable pulse to the engine |
| eng_irq_clr | output | 1 | Interrupt flag acknowledge pulse |
| cpl_valid | output | 1 | Request finished |
| cpl_tag | output | TAG_W | Tag of the finished request |
| qry_tag | input | TAG_W | Tag to look up |
| qry_residue | output | LEN_W | Remaining bytes of the tagged request, 0 if not held |
| timeout_err | output | 1 | Sticky idle-wait timeout flag |

## Verification
Several properties are checked on every cycle:
- The length on every start lies between 1 and MAX.
- Every start is preceded by a warm reset.
- The engine registers hold steady while a transfer runs.
- The error flag never drops.
- The queue never exceeds its depth or pops when empty.
- A completion is reported only while the head residue is zero.

The bench scenarios show what these properties cannot:
- the exact piece lengths and address steps of a multi-piece request;
- the order of requests and completions across a full queue with stalled input;
- residue answers for queued, active and unknown tags;
- the zero-length path;
- recovery after an idle wait that expires.

// File: rtl/cqsplit_pkg.sv
package cqsplit_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WAIT_A,
      ST_WRST,
      ST_WAIT_B,
      ST_PROG,
      ST_GO,
      ST_RUN,
      ST_CLR,
      ST_DONE
   } seq_state_e;

   function automatic int unsigned ctr_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/cqsplit_queue.sv
module cqsplit_queue #(
   parameter int unsigned ADDR_W = 40,
   parameter int unsigned LEN_W  = 32,
   parameter int unsigned TAG_W  = 4,
   parameter int unsigned DEPTH  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [ADDR_W-1:0]       in_src,
   input  logic [ADDR_W-1:0]       in_dst,
   input  logic [LEN_W-1:0]        in_len,
   input  logic [TAG_W-1:0]        in_tag,
   output logic                    head_valid,
   output logic [ADDR_W-1:0]       head_src,
   output logic [ADDR_W-1:0]       head_dst,
   output logic [LEN_W-1:0]        head_res,
   output logic [TAG_W-1:0]        head_tag,
   input  logic                    adv,
   input  logic [LEN_W-1:0]        adv_len,
   input  logic                    pop,
   output logic [DEPTH-1:0]        slot_valid,
   output logic [DEPTH*TAG_W-1:0]  slot_tags,
   output logic [DEPTH*LEN_W-1:0]  slot_res
);
   localparam int unsigned PTR_W = $clog2(DEPTH);
   localparam int unsigned CNT_W = PTR_W + 1;

   logic [ADDR_W-1:0] src_q [DEPTH];
   logic [ADDR_W-1:0] dst_q [DEPTH];
   logic [LEN_W-1:0]  res_q [DEPTH];
   logic [TAG_W-1:0]  tag_q [DEPTH];

   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] count;
   logic             push;

   assign in_ready   = (count < CNT_W'(DEPTH));
   assign push       = in_valid && in_ready;
   assign head_valid = (count != '0);
   assign head_src   = src_q[rd_ptr];
   assign head_dst   = dst_q[rd_ptr];
   assign head_res   = res_q[rd_ptr];
   assign head_tag   = tag_q[rd_ptr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) begin
            src_q[wr_ptr] <= in_src;
            dst_q[wr_ptr] <= in_dst;
            res_q[wr_ptr] <= in_len;
            tag_q[wr_ptr] <= in_tag;
            wr_ptr        <= wr_ptr + 1'b1;
         end
         if (adv) begin
            src_q[rd_ptr] <= src_q[rd_ptr] + ADDR_W'(adv_len);
            dst_q[rd_ptr] <= dst_q[rd_ptr] + ADDR_W'(adv_len);
            res_q[rd_ptr] <= res_q[rd_ptr] - adv_len;
         end
         if (pop) rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [PTR_W-1:0] offset;
      assign offset = PTR_W'(i) - rd_ptr;
      assign slot_valid[i] = ({1'b0, offset} < count);
      assign slot_tags[i*TAG_W +: TAG_W] = tag_q[i];
      assign slot_res[i*LEN_W +: LEN_W]  = res_q[i];
   end

   a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   a_r6_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (count != '0));

endmodule

// File: rtl/cqsplit_lookup.sv
module cqsplit_lookup #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned TAG_W = 4,
   parameter int unsigned LEN_W = 32
) (
   input  logic [DEPTH-1:0]       slot_valid,
   input  logic [DEPTH*TAG_W-1:0] slot_tags,
   input  logic [DEPTH*LEN_W-1:0] slot_res,
   input  logic [TAG_W-1:0]       qry_tag,
   output logic [LEN_W-1:0]       qry_residue
);
   logic [LEN_W-1:0] masked [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_match
      logic hit;
      assign hit       = slot_valid[i] && (slot_tags[i*TAG_W +: TAG_W] == qry_tag);
      assign masked[i] = hit ? slot_res[i*LEN_W +: LEN_W] : '0;
   end

   always_comb begin
      qry_residue = '0;
      for (int i = 0; i < DEPTH; i++) qry_residue = qry_residue | masked[i];
   end

endmodule

// File: rtl/cqsplit_seq.sv
module cqsplit_seq
   import cqsplit_pkg::*;
#(
   parameter int unsigned ADDR_W  = 40,
   parameter int unsigned LEN_W   = 32,
   parameter int unsigned CHUNK_W = 28,
   parameter int unsigned TIMEOUT = 100
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               head_valid,
   input  logic [ADDR_W-1:0]  head_src,
   input  logic [ADDR_W-1:0]  head_dst,
   input  logic [LEN_W-1:0]   head_res,
   input  logic               eng_busy,
   input  logic               eng_done,
   output logic               eng_wrst,
   output logic [ADDR_W-1:0]  eng_src,
   output logic [ADDR_W-1:0]  eng_dst,
   output logic [CHUNK_W-1:0] eng_len,
   output logic               eng_start,
   output logic               eng_irq_clr,
   output logic               adv,
   output logic [LEN_W-1:0]   adv_len,
   output logic               pop,
   output logic               done_valid,
   output logic               timeout_err
);
   localparam int unsigned      TMR_W    = ctr_width(TIMEOUT);
   localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT - 1);
   localparam logic [CHUNK_W-1:0] MAX_C  = '1;

   seq_state_e         st;
   logic [TMR_W-1:0]   tmr;
   logic [ADDR_W-1:0]  src_q, dst_q;
   logic [CHUNK_W-1:0] len_q;
   logic [CHUNK_W-1:0] next_len;
   logic               err_q;
   logic               wait_over;

   if (LEN_W > CHUNK_W) begin : g_split
      logic [LEN_W-1:0] max_wide;
      assign max_wide = {{(LEN_W-CHUNK_W){1'b0}}, MAX_C};
      assign next_len = (head_res > max_wide) ? MAX_C : head_res[CHUNK_W-1:0];
   end else begin : g_whole
      assign next_len = CHUNK_W'(head_res);
   end

   assign wait_over = !eng_busy || (tmr == TMR_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         tmr   <= '0;
         src_q <= '0;
         dst_q <= '0;
         len_q <= '0;
         err_q <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: begin
               tmr <= '0;
               if (head_valid) st <= (head_res == '0) ? ST_DONE : ST_WAIT_A;
            end
            ST_WAIT_A: begin
               if (wait_over) begin
                  if (eng_busy) err_q <= 1'b1;
                  st <= ST_WRST;
               end else begin
                  tmr <= tmr + 1'b1;
               end
            end
            ST_WRST: begin
               tmr <= '0;
               st  <= ST_WAIT_B;
            end
            ST_WAIT_B: begin
               if (wait_over) begin
                  if (eng_busy) err_q <= 1'b1;
                  st <= ST_PROG;
               end else begin
                  tmr <= tmr + 1'b1;
               end
            end
            ST_PROG: begin
               src_q <= head_src;
               dst_q <= head_dst;
               len_q <= next_len;
               st    <= ST_GO;
            end
            ST_GO:   st <= ST_RUN;
            ST_RUN:  if (eng_done) st <= ST_CLR;
            ST_CLR:  st <= (head_res == LEN_W'(len_q)) ? ST_DONE : ST_IDLE;
            ST_DONE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign eng_wrst    = (st == ST_WRST);
   assign eng_start   = (st == ST_GO);
   assign eng_irq_clr = (st == ST_CLR);
   assign adv         = (st == ST_CLR);
   assign adv_len     = LEN_W'(len_q);
   assign pop         = (st == ST_DONE);
   assign done_valid  = (st == ST_DONE);
   assign eng_src     = src_q;
   assign eng_dst     = dst_q;
   assign eng_len     = len_q;
   assign timeout_err = err_q;

   logic rst_seen;
   always_ff @(posedge clk) begin
      if (!rst_n)         rst_seen <= 1'b0;
      else if (eng_wrst)  rst_seen <= 1'b1;
      else if (eng_start) rst_seen <= 1'b0;
   end

   a_r4_wrst_before_start: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> rst_seen);

   a_r2_len_range: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> (eng_len != '0));

   a_r3_regs_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN) |=> ($stable(eng_src) && $stable(eng_dst) && $stable(eng_len)));

   a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_err |=> timeout_err);

endmodule

// File: rtl/copy_split_queue.sv
module copy_split_queue #(
   parameter int unsigned ADDR_W  = 40,
   parameter int unsigned LEN_W   = 32,
   parameter int unsigned CHUNK_W = 28,
   parameter int unsigned TAG_W   = 4,
   parameter int unsigned DEPTH   = 4,
   parameter int unsigned TIMEOUT = 100
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [ADDR_W-1:0]  req_src,
   input  logic [ADDR_W-1:0]  req_dst,
   input  logic [LEN_W-1:0]   req_len,
   input  logic [TAG_W-1:0]   req_tag,
   input  logic               eng_busy,
   input  logic               eng_done,
   output logic               eng_wrst,
   output logic [ADDR_W-1:0]  eng_src,
   output logic [ADDR_W-1:0]  eng_dst,
   output logic [CHUNK_W-1:0] eng_len,
   output logic               eng_start,
   output logic               eng_irq_clr,
   output logic               cpl_valid,
   output logic [TAG_W-1:0]   cpl_tag,
   input  logic [TAG_W-1:0]   qry_tag,
   output logic [LEN_W-1:0]   qry_residue,
   output logic               timeout_err
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end
   if (CHUNK_W < 1 || ADDR_W < 1 || LEN_W < 1 || TAG_W < 1) begin : g_bad_width
      $error("all widths must be at least 1");
   end
   if (TIMEOUT < 1) begin : g_bad_timeout
      $error("TIMEOUT must be at least 1");
   end

   logic               head_valid;
   logic [ADDR_W-1:0]  head_src, head_dst;
   logic [LEN_W-1:0]   head_res;
   logic [TAG_W-1:0]   head_tag;
   logic               adv, pop;
   logic [LEN_W-1:0]   adv_len;
   logic [DEPTH-1:0]   slot_valid;
   logic [DEPTH*TAG_W-1:0] slot_tags;
   logic [DEPTH*LEN_W-1:0] slot_res;

   cqsplit_queue #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .TAG_W(TAG_W), .DEPTH(DEPTH)
   ) u_queue (
      .clk(clk), .rst_n(rst_n),
      .in_valid(req_valid), .in_ready(req_ready),
      .in_src(req_src), .in_dst(req_dst), .in_len(req_len), .in_tag(req_tag),
      .head_valid(head_valid), .head_src(head_src), .head_dst(head_dst),
      .head_res(head_res), .head_tag(head_tag),
      .adv(adv), .adv_len(adv_len), .pop(pop),
      .slot_valid(slot_valid), .slot_tags(slot_tags), .slot_res(slot_res)
   );

   cqsplit_seq #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CHUNK_W(CHUNK_W), .TIMEOUT(TIMEOUT)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .head_valid(head_valid), .head_src(head_src), .head_dst(head_dst),
      .head_res(head_res),
      .eng_busy(eng_busy), .eng_done(eng_done),
      .eng_wrst(eng_wrst), .eng_src(eng_src), .eng_dst(eng_dst),
      .eng_len(eng_len), .eng_start(eng_start), .eng_irq_clr(eng_irq_clr),
      .adv(adv), .adv_len(adv_len), .pop(pop),
      .done_valid(cpl_valid), .timeout_err(timeout_err)
   );

   cqsplit_lookup #(
      .DEPTH(DEPTH), .TAG_W(TAG_W), .LEN_W(LEN_W)
   ) u_lookup (
      .slot_valid(slot_valid), .slot_tags(slot_tags), .slot_res(slot_res),
      .qry_tag(qry_tag), .qry_residue(qry_residue)
   );

   assign cpl_tag = head_tag;

   a_r6_cpl_zero_residue: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_valid |-> (head_valid && head_res == '0));

   a_r6_clr_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      eng_irq_clr |-> eng_done);

endmodule

// File: tb/sim_copy_split_queue.sv
`timescale 1ns/1ps
module sim_copy_split_queue;
   localparam logic [31:0] MAX = 32'h0FFF_FFFF;

   typedef struct packed {
      logic [39:0] s;
      logic [39:0] d;
      logic [27:0] l;
      logic [3:0]  t;
   } chunk_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [39:0] req_src = '0, req_dst = '0;
   logic [31:0] req_len = '0;
   logic [3:0]  req_tag = '0;
   logic eng_busy, eng_done;
   logic eng_wrst, eng_start, eng_irq_clr;
   logic [39:0] eng_src, eng_dst;
   logic [27:0] eng_len;
   logic cpl_valid;
   logic [3:0] cpl_tag;
   logic [3:0] qry_tag = '0;
   logic [31:0] qry_residue;
   logic timeout_err;

   int checks = 0, errors = 0;
   int start_cnt = 0, clr_cnt = 0, eng_cmp_cnt = 0;
   int run_cycles = 6;
   bit hold_busy = 1'b0;
   bit seen_wrst = 1'b0;
   bit finished = 1'b0;
   chunk_t exp_q[$];
   logic [3:0] exp_done[$];

   always #2.5 clk = ~clk;

   copy_split_queue u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_src(req_src), .req_dst(req_dst), .req_len(req_len), .req_tag(req_tag),
      .eng_busy(eng_busy), .eng_done(eng_done),
      .eng_wrst(eng_wrst), .eng_src(eng_src), .eng_dst(eng_dst),
      .eng_len(eng_len), .eng_start(eng_start), .eng_irq_clr(eng_irq_clr),
      .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
      .qry_tag(qry_tag), .qry_residue(qry_residue),
      .timeout_err(timeout_err)
   );

   // engine model
   logic [7:0] bcnt;
   logic running, done_r;
   always @(posedge clk) begin
      if (!rst_n) begin
         bcnt <= '0; running <= 1'b0; done_r <= 1'b0;
      end else begin
         if (eng_start) begin
            bcnt <= 8'(run_cycles); running <= 1'b1;
         end else if (eng_wrst) begin
            bcnt <= 8'd2;
         end else if (bcnt != 0) begin
            bcnt <= bcnt - 1'b1;
            if (bcnt == 8'd1 && running) begin
               done_r <= 1'b1; running <= 1'b0; eng_cmp_cnt <= eng_cmp_cnt + 1;
            end
         end
         if (eng_irq_clr) done_r <= 1'b0;
      end
   end
   assign eng_busy = (bcnt != 0) || hold_busy;
   assign eng_done = done_r;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (eng_wrst) seen_wrst = 1'b1;
         if (eng_start) begin
            start_cnt++;
            chk(seen_wrst, "R4 warm reset before start", 64'(seen_wrst), 64'd1);
            seen_wrst = 1'b0;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R2 unexpected transfer", 64'(eng_len), 64'd0);
            end else begin
               chunk_t e;
               e = exp_q.pop_front();
               chk(eng_len == e.l, "R2 transfer length", 64'(eng_len), 64'(e.l));
               chk(eng_src == e.s, "R3 source address", 64'(eng_src), 64'(e.s));
               chk(eng_dst == e.d, "R3 destination address", 64'(eng_dst), 64'(e.d));
            end
         end
         if (eng_irq_clr) clr_cnt++;
         if (cpl_valid) begin
            if (exp_done.size() == 0) begin
               chk(1'b0, "R6 unexpected completion", 64'(cpl_tag), 64'd0);
            end else begin
               logic [3:0] t;
               bit pending;
               t = exp_done.pop_front();
               chk(cpl_tag == t, "R7 completion order", 64'(cpl_tag), 64'(t));
               pending = 1'b0;
               foreach (exp_q[i]) if (exp_q[i].t == cpl_tag) pending = 1'b1;
               chk(!pending, "R6 completion before last transfer", 64'(pending), 64'd0);
            end
         end
      end
   end

   task automatic push_req(input logic [39:0] s, input logic [39:0] d,
                           input logic [31:0] l, input logic [3:0] t);
      logic [31:0] rem;
      logic [39:0] cs, cd;
      rem = l; cs = s; cd = d;
      while (rem != 0) begin
         chunk_t c;
         logic [31:0] n;
         n = (rem > MAX) ? MAX : rem;
         c.s = cs; c.d = cd; c.l = n[27:0]; c.t = t;
         exp_q.push_back(c);
         cs = cs + 40'(n); cd = cd + 40'(n); rem = rem - n;
      end
      exp_done.push_back(t);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_src = s; req_dst = d; req_len = l; req_tag = t;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic drain(input string req);
      int n = 0;
      while (exp_done.size() != 0 && n < 20000) begin
         @(negedge clk); n++;
      end
      chk(exp_done.size() == 0, req, 64'(exp_done.size()), 64'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(req_ready == 1'b1, "R10 ready after reset", 64'(req_ready), 64'd1);
      chk(timeout_err == 1'b0, "R10 error clear", 64'(timeout_err), 64'd0);
      chk(!cpl_valid && !eng_start && !eng_wrst && !eng_irq_clr, "R10 pulses idle",
          64'({cpl_valid, eng_start, eng_wrst, eng_irq_clr}), 64'd0);
      qry_tag = 4'd3;
      #0.1 chk(qry_residue == 0, "R8 unknown tag at reset", 64'(qry_residue), 64'd0);

      // single short request
      push_req(40'h10_0000_0000, 40'h20_0000_0000, 32'd100, 4'd1);
      drain("R2 short request completes");

      // exact MAX and MAX+1
      push_req(40'h00_1000_0000, 40'h00_8000_0000, MAX, 4'd2);
      push_req(40'h00_0000_1000, 40'h00_0000_9000, MAX + 32'd1, 4'd3);
      drain("R2 boundary lengths complete");

      // fill queue with a long head request
      run_cycles = 30;
      base = start_cnt;
      push_req(40'hAB_0000_0000, 40'hCD_0000_0000, 2*MAX + 32'd10, 4'd4);
      push_req(40'h01_0000_0000, 40'h02_0000_0000, 32'd50, 4'd5);
      push_req(40'h03_0000_0000, 40'h04_0000_0000, 32'h1234, 4'd6);
      push_req(40'h05_0000_0000, 40'h06_0000_0000, 32'd7, 4'd7);
      chk(req_ready == 1'b0, "R1 ready low when full", 64'(req_ready), 64'd0);
      qry_tag = 4'd6;
      #0.1 chk(qry_residue == 32'h1234, "R8 queued residue", 64'(qry_residue), 64'h1234);
      wait (start_cnt == base + 2);
      @(negedge clk);
      qry_tag = 4'd4;
      #0.1 chk(qry_residue == MAX + 32'd10, "R8 active residue", 64'(qry_residue), 64'(MAX + 32'd10));
      qry_tag = 4'd14;
      #0.1 chk(qry_residue == 0, "R8 unknown tag", 64'(qry_residue), 64'd0);
      push_req(40'h07_0000_0000, 40'h08_0000_0000, 32'd300, 4'd8);
      drain("R7 full queue drains in order");
      qry_tag = 4'd4;
      #0.1 chk(qry_residue == 0, "R8 finished tag", 64'(qry_residue), 64'd0);
      run_cycles = 6;

      // zero-length request
      base = start_cnt;
      push_req(40'h0, 40'h0, 32'd0, 4'd9);
      drain("R9 zero-length completes");
      chk(start_cnt == base, "R9 no engine start", 64'(start_cnt - base), 64'd0);

      // idle wait timeout
      chk(timeout_err == 1'b0, "R5 error clear before stall", 64'(timeout_err), 64'd0);
      hold_busy = 1'b1;
      base = start_cnt;
      push_req(40'h11_0000_0000, 40'h22_0000_0000, 32'd64, 4'd10);
      wait (start_cnt == base + 1);
      @(negedge clk);
      chk(timeout_err == 1'b1, "R5 error set on stall", 64'(timeout_err), 64'd1);
      hold_busy = 1'b0;
      drain("R5 request completes after timeout");
      repeat (3) @(negedge clk);
      chk(timeout_err == 1'b1, "R5 error sticky", 64'(timeout_err), 64'd1);

      chk(clr_cnt == eng_cmp_cnt, "R6 one acknowledge per engine completion",
          64'(clr_cnt), 64'(eng_cmp_cnt));
      chk(exp_q.size() == 0, "R2 all transfers seen", 64'(exp_q.size()), 64'd0);

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule